// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the software-visible control and status state of one bus-master DMA channel inside a disk-interface controller. It is reached over a small byte-addressed register port that carries a read strobe, a write strobe, a byte offset, an access size in bytes and a 32-bit data word. There are three registers: a command byte, a status byte and a 32-bit pointer to the descriptor table in memory.

When software flips the start bit in the command byte, the block sends a one-cycle start or abort pulse to the DMA engine that sits beside it. The start pulse comes with the descriptor pointer as it stood at that moment. When the engine finishes, it raises a completion strobe. The block then stops the channel, drops the active flag and posts an interrupt that stays pending until software clears it. Access-size violations, and an attempt to start or stop while no drive is selected, are reported on a one-cycle error output. Such a write changes nothing.

Byte map, little-endian:
- Offset 0 is the command byte.
- Offset 2 is the status byte.
- Offsets 4 to 7 hold the pointer.
- Offsets 1 and 3 always read as zero.

Command bit 0 is start. The other command bits are stored as written. Status bits:
- Bit 0 is active (read-only).
- Bit 1 is the DMA error (write 1 to clear).
- Bit 2 is the interrupt (write 1 to clear).
- Bits 5 and 6 are the two drive-capable flags.
- Bits 3, 4 and 7 are stored as written.

Top module: `bmdma_chan_regs`

## Requirements
- R1: After reset, the command byte reads 0x00, the status byte reads 0x60 (both drive-capable bits set, all else 0), the pointer reads 0, and irq_o is low.
- R2: A byte write to offset 0 that changes command bit 0 from 0 to 1, with a drive selected, sets status bit 0. In the cycle after the write, start_o is high for one cycle and start_ptr_o carries the pointer.
- R3: A byte write to offset 0 that changes command bit 0 from 1 to 0, with a drive selected, clears status bit 0. In the cycle after the write, abort_o is high for one cycle.
- R4: A write to the status byte never changes status bit 0.
- R5: Status bits 1 and 2 become 0 only when they are 1 and the write to offset 2 carries a 1 in that position. Otherwise they keep their value. irq_o equals status bit 2.
- R6: A write to offset 4 is taken only with size 4, and pointer bits 1:0 are stored as 0. Any other size at offset 4 leaves the pointer unchanged and pulses err_o in the next cycle.
- R7: A write to offset 0 or 2 with a size other than 1 changes no register, issues no pulse, and pulses err_o in the next cycle.
- R8: dma_done_i clears command bit 0 and status bit 0, and sets status bit 2, at the same clock edge. It issues no start or abort pulse.
- R9: A write that would change command bit 0 while drv_sel_i is low pulses err_o, issues no start or abort pulse and leaves the command byte unchanged.
- R10: With rd_i high, rdata_o returns size_i bytes of the register image from off_i upward in little-endian order. Bytes beyond the requested size, or beyond offset 7, read as 0.
- R11: When dma_done_i and a status write that clears bit 2 fall in the same cycle, status bit 2 ends at 1.
- R12: A command write that leaves bit 0 at its current value issues no start or abort pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| off_i | input | 3 | Byte offset of the access |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| wdata_i | input | 32 | Write data, little-endian from the offset |
| rdata_o | output | 32 | Read data, combinational |
| drv_sel_i | input | 1 | A drive is selected on this channel |
| dma_done_i | input | 1 | Completion strobe from the DMA engine |
| start_o | output | 1 | One-cycle start request |
| abort_o | output | 1 | One-cycle abort request |
| start_ptr_o | output | 32 | Descriptor pointer captured with the start request |
| err_o | output | 1 | One-cycle access error indication |
| irq_o | output | 1 | Interrupt pending |

## Verification
The start/stop logic is driven four ways: a real 0 to 1 edge, a rewrite of the same value, a real 1 to 0 edge, and an edge with no drive selected. Between them these separate edge detection from level detection, and the selection check from the pulse path.

Status writes use patterns with the clear bits at 0 and at 1, while the flags are set and while they are clear. This tells true write-one-to-clear apart from plain storage and from a plain clear. Completion is applied alone and together with a clearing write, to pin down which one wins.

Reads at odd offsets and sizes that run past the end of the image show lane ordering and zero fill.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned OFF_CMD   = 0;
  localparam int unsigned OFF_STS   = 2;
  localparam int unsigned OFF_PTR   = 4;
  localparam int unsigned CMD_START = 0;
  localparam int unsigned STS_ACT   = 0;
  localparam int unsigned STS_ERR   = 1;
  localparam int unsigned STS_IRQ   = 2;
  localparam logic [7:0]  STS_RST   = 8'h60;

  typedef struct packed {
    logic cmd;
    logic sts;
    logic ptr;
    logic bad;
  } wr_dec_t;
endpackage

// File: rtl/bmdma_wr_decode.sv
module bmdma_wr_decode
  import bmdma_pkg::*;
#(
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  output wr_dec_t           dec_o
);
  localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(1);
  localparam logic [SIZE_W-1:0] SZ_PTR  = SIZE_W'(DATA_W / 8);

  always_comb begin
    dec_o = '0;
    if (wr_i) begin
      unique case (off_i)
        OFF_W'(OFF_CMD): if (size_i == SZ_BYTE) dec_o.cmd = 1'b1; else dec_o.bad = 1'b1;
        OFF_W'(OFF_STS): if (size_i == SZ_BYTE) dec_o.sts = 1'b1; else dec_o.bad = 1'b1;
        OFF_W'(OFF_PTR): if (size_i == SZ_PTR)  dec_o.ptr = 1'b1; else dec_o.bad = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_cmd_ctrl.sv
module bmdma_cmd_ctrl
  import bmdma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              drv_sel_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] ptr_i,
  output logic [7:0]        cmd_o,
  output logic              active_o,
  output logic              start_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] start_ptr_o,
  output logic              sel_err_o
);
  logic [7:0] cmd_q;
  logic       toggle;

  assign toggle    = we_i && (wdata_i[CMD_START] != cmd_q[CMD_START]);
  assign sel_err_o = toggle && !drv_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q       <= '0;
      active_o    <= 1'b0;
      start_o     <= 1'b0;
      abort_o     <= 1'b0;
      start_ptr_o <= '0;
    end else begin
      start_o <= 1'b0;
      abort_o <= 1'b0;
      if (done_i) begin
        // completion wins over any start/stop in the same cycle
        if (we_i && !sel_err_o) cmd_q <= {wdata_i[7:1], 1'b0};
        else                    cmd_q[CMD_START] <= 1'b0;
        active_o <= 1'b0;
      end else if (we_i && !sel_err_o) begin
        cmd_q <= wdata_i;
        if (toggle) begin
          if (wdata_i[CMD_START]) begin
            start_o     <= 1'b1;
            active_o    <= 1'b1;
            start_ptr_o <= ptr_i;
          end else begin
            abort_o  <= 1'b1;
            active_o <= 1'b0;
          end
        end
      end
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/bmdma_status_reg.sv
module bmdma_status_reg
  import bmdma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       done_i,
  output logic [7:1] sts_o
);
  logic [7:3] plain_q;
  logic       err_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      plain_q <= STS_RST[7:3];
      err_q   <= STS_RST[STS_ERR];
      irq_q   <= STS_RST[STS_IRQ];
    end else begin
      if (we_i) begin
        plain_q <= wdata_i[7:3];
        err_q   <= err_q & ~wdata_i[STS_ERR];
        irq_q   <= irq_q & ~wdata_i[STS_IRQ];
      end
      if (done_i) irq_q <= 1'b1;
    end
  end

  assign sts_o = {plain_q, irq_q, err_q};
endmodule

// File: rtl/bmdma_rd_mux.sv
module bmdma_rd_mux #(
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic                        rd_i,
  input  logic [OFF_W-1:0]            off_i,
  input  logic [SIZE_W-1:0]           size_i,
  input  logic [(2**OFF_W)*8-1:0]     img_i,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned LANES = DATA_W / 8;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [OFF_W:0] idx;
    assign idx = {1'b0, off_i} + (OFF_W+1)'(k);
    always_comb begin
      rdata_o[k*8 +: 8] = 8'h00;
      if (rd_i && (SIZE_W'(k) < size_i) && !idx[OFF_W])
        rdata_o[k*8 +: 8] = img_i[idx[OFF_W-1:0]*8 +: 8];
    end
  end
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              drv_sel_i,
  input  logic              dma_done_i,
  output logic              start_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] start_ptr_o,
  output logic              err_o,
  output logic              irq_o
);
  localparam int unsigned IMG_BYTES = 2 ** OFF_W;

  wr_dec_t             dec;
  logic [7:0]          cmd;
  logic [7:1]          sts;
  logic                active_q;
  logic                sel_err;
  logic [DATA_W-1:0]   ptr_q;
  logic [IMG_BYTES*8-1:0] img;

  bmdma_wr_decode #(.OFF_W(OFF_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_dec (
    .wr_i(wr_i), .off_i(off_i), .size_i(size_i), .dec_o(dec)
  );

  bmdma_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dec.cmd), .wdata_i(wdata_i[7:0]),
    .drv_sel_i(drv_sel_i), .done_i(dma_done_i), .ptr_i(ptr_q),
    .cmd_o(cmd), .active_o(active_q), .start_o(start_o), .abort_o(abort_o),
    .start_ptr_o(start_ptr_o), .sel_err_o(sel_err)
  );

  bmdma_status_reg u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dec.sts), .wdata_i(wdata_i[7:0]),
    .done_i(dma_done_i), .sts_o(sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      err_o <= 1'b0;
    end else begin
      if (dec.ptr) ptr_q <= {wdata_i[DATA_W-1:2], 2'b00};
      err_o <= dec.bad | sel_err;
    end
  end

  always_comb begin
    img = '0;
    img[OFF_CMD*8 +: 8]      = cmd;
    img[OFF_STS*8 +: 8]      = {sts, active_q};
    img[OFF_PTR*8 +: DATA_W] = ptr_q;
  end

  bmdma_rd_mux #(.OFF_W(OFF_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_rd (
    .rd_i(rd_i), .off_i(off_i), .size_i(size_i), .img_i(img), .rdata_o(rdata_o)
  );

  assign irq_o = sts[STS_IRQ];
endmodule

// File: rtl/bmdma_chan_regs_chk.sv
module bmdma_chan_regs_chk #(
  parameter int unsigned OFF_W  = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [OFF_W-1:0]  off_i,
  input logic              dma_done_i,
  input logic              start_o,
  input logic              abort_o,
  input logic              err_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] start_ptr_o,
  input logic              active_q
);
  p_start_active_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> active_q);
  p_abort_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !active_q);
  p_active_ro_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_W'(2) && !dma_done_i) |=> $stable(active_q));
  p_ptr_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (start_ptr_o[1:0] == 2'b00));
  p_done_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> (irq_o && !active_q && !start_o && !abort_o));
  p_err_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!start_o && !abort_o));
  p_one_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && abort_o));
endmodule

bind bmdma_chan_regs bmdma_chan_regs_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .off_i(off_i),
  .dma_done_i(dma_done_i), .start_o(start_o), .abort_o(abort_o),
  .err_o(err_o), .irq_o(irq_o), .start_ptr_o(start_ptr_o), .active_q(active_q)
);

// File: tb/bmdma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module bmdma_chan_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0]  off_i = '0, size_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        drv_sel_i = 1'b1, dma_done_i = 1'b0;
  logic        start_o, abort_o, err_o, irq_o;
  logic [31:0] start_ptr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bmdma_chan_regs dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .off_i(off_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .drv_sel_i(drv_sel_i),
    .dma_done_i(dma_done_i), .start_o(start_o), .abort_o(abort_o),
    .start_ptr_o(start_ptr_o), .err_o(err_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write then return at the following negedge, where registered pulses are visible
  task automatic wr(input logic [2:0] off, input logic [2:0] sz,
                    input logic [31:0] d, input bit done = 1'b0);
    @(negedge clk_i);
    wr_i = 1'b1; off_i = off; size_i = sz; wdata_i = d; dma_done_i = done;
    @(negedge clk_i);
    wr_i = 1'b0; dma_done_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [2:0] sz, output logic [31:0] d);
    rd_i = 1'b1; off_i = off; size_i = sz;
    #1 d = rdata_o;
    rd_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk_i);
    rd(0, 4, d); chk("R1 cmd/sts image", d, 32'h0060_0000);
    rd(4, 4, d); chk("R1 pointer", d, 32'h0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_ptr;
    logic [31:0] d;
    wr(4, 4, 32'h1234_5677);
    rd(4, 4, d); chk("R6 aligned ptr", d, 32'h1234_5674);
    wr(4, 2, 32'hFFFF_FFFF);
    chk("R6 err on short ptr write", err_o, 1);
    rd(4, 4, d); chk("R6 ptr kept", d, 32'h1234_5674);
  endtask

  task automatic t_read;
    logic [31:0] d;
    rd(4, 1, d); chk("R10 byte read", d, 32'h74);
    rd(5, 2, d); chk("R10 half read", d, 32'h3456);
    rd(6, 4, d); chk("R10 read past end", d, 32'h0000_1234);
  endtask

  task automatic t_start;
    logic [31:0] d;
    drv_sel_i = 1'b1;
    wr(0, 1, 32'h09);
    chk("R2 start pulse", start_o, 1);
    chk("R2 start ptr", start_ptr_o, 32'h1234_5674);
    rd(2, 1, d); chk("R2 active set", d, 32'h61);
    @(negedge clk_i);
    chk("R2 pulse one cycle", start_o, 0);
  endtask

  task automatic t_same;
    logic [31:0] d;
    wr(0, 1, 32'h01);
    chk("R12 no start on rewrite", start_o, 0);
    chk("R12 no abort on rewrite", abort_o, 0);
    rd(0, 1, d); chk("R12 cmd stored", d, 32'h01);
  endtask

  task automatic t_active_ro;
    logic [31:0] d;
    wr(2, 1, 32'h00);
    rd(2, 1, d); chk("R4 active kept", d, 32'h01);
    wr(2, 1, 32'h60);
    rd(2, 1, d); chk("R4 status restore", d, 32'h61);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    wr(0, 1, 32'h00);
    chk("R3 abort pulse", abort_o, 1);
    chk("R3 no start", start_o, 0);
    rd(2, 1, d); chk("R3 active clear", d, 32'h60);
  endtask

  task automatic t_size_err;
    logic [31:0] d;
    wr(0, 2, 32'h0001);
    chk("R7 err on cmd half write", err_o, 1);
    chk("R7 no start", start_o, 0);
    rd(0, 1, d); chk("R7 cmd unchanged", d, 32'h00);
    wr(2, 4, 32'h0000_0000);
    chk("R7 err on sts word write", err_o, 1);
    rd(2, 1, d); chk("R7 sts unchanged", d, 32'h60);
  endtask

  task automatic t_nosel;
    logic [31:0] d;
    drv_sel_i = 1'b0;
    wr(0, 1, 32'h01);
    chk("R9 err without drive", err_o, 1);
    chk("R9 no start", start_o, 0);
    rd(0, 1, d); chk("R9 cmd unchanged", d, 32'h00);
    drv_sel_i = 1'b1;
  endtask

  task automatic t_done;
    logic [31:0] d;
    wr(0, 1, 32'h01);
    @(negedge clk_i); dma_done_i = 1'b1;
    @(negedge clk_i); dma_done_i = 1'b0;
    rd(0, 1, d); chk("R8 start cleared", d, 32'h00);
    rd(2, 1, d); chk("R8 active clear irq set", d, 32'h64);
    chk("R8 irq out", irq_o, 1);
    chk("R8 no abort", abort_o, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(2, 1, 32'h60);
    rd(2, 1, d); chk("R5 irq kept on 0", d, 32'h64);
    wr(2, 1, 32'h64);
    rd(2, 1, d); chk("R5 irq cleared on 1", d, 32'h60);
    chk("R5 irq out low", irq_o, 0);
    wr(2, 1, 32'h62);
    rd(2, 1, d); chk("R5 err stays 0", d, 32'h60);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    @(negedge clk_i); dma_done_i = 1'b1;
    @(negedge clk_i); dma_done_i = 1'b0;
    wr(2, 1, 32'h64, 1'b1);
    rd(2, 1, d); chk("R11 done wins over clear", d, 32'h64);
    chk("R11 irq out", irq_o, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_ptr();
    t_read();
    t_start();
    t_same();
    t_active_ro();
    t_stop();
    t_size_err();
    t_nosel();
    t_done();
    t_w1c();
    t_prio();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule